// File: doc/BRIEF.md
# Memory Controller Status and Fault Register File

This block is the software-visible register file of an error-correcting memory controller. It holds nine 32-bit word registers: memory enable, timing delay, fault status, video configuration, two fault-address words, diagnostic, and two event counters. A processor reaches them over a simple word bus. The bus has a byte address, a write strobe, write data and combinational read data. The word index is the byte address shifted right by two. Index order: 0 enable, 1 delay, 2 fault status, 3 video, 4 fault address 0, 5 fault address 1, 6 diagnostic, 7 event count 0, 8 event count 1.

The controller's checking logic reports each detected error on a one-cycle capture strobe. The strobe carries the error class, a syndrome, a double-word index and two address words. The block records the event in the fault status and fault-address registers and may raise an interrupt. The interrupt comes from a two-state machine:
- `IRQ_QUIET` goes to `IRQ_ALERT` on a capture that qualifies for an interrupt ("raise").
- `IRQ_ALERT` goes back to `IRQ_QUIET` on a bus write to the fault status register in a cycle with no qualifying capture ("acknowledge"), or on a soft reset ("flush").
- Every other case holds the state.

The parameter `VARIANT` (0, 1 or 2) selects one of three chip variants. It sets the writable bits of the enable register and the enable bits that survive a soft reset. It also decides whether a four-byte diagnostic byte window exists; only variant 0 has it. There are two resets. `por_n` is an asynchronous power-on reset that loads every register. `soft_rst` is a synchronous reset that keeps a variant-dependent set of enable bits.

Top module: `memctl_regfile`

## Requirements
- R1: Reads return the register at word index `bus_addr[5:2]`. Indexes 9 to 15 read as zero, and writes to them change no register.
- R2: A write to the enable register (index 0) keeps `wdata & 0x00000103` for variant 0. For variants 1 and 2 it keeps `wdata & 0x00000BFF`. Bits 31:28 always read the variant number and bits 27:24 read zero.
- R3: A write to the delay register (index 1) stores `wdata & 0x7FFFFFFF`.
- R4: After power-on reset the registers read as follows: enable = variant number in bits 31:28, delay = 0x00000020, fault address 0 = 0x07C00000, all others 0, and `irq` low.
- R5: A soft reset keeps only enable bit 8 for variant 0. For variants 1 and 2 it keeps enable bits 31:24, 11 and 9:2. It returns every other register to its R4 value and drives `irq` low in the next cycle.
- R6: A bus write to the fault status register (index 2) stores the full word, and with no capture in that cycle `irq` is low after that edge (`IRQ_ALERT` to `IRQ_QUIET`).
- R7: Writes to indexes 4 and 5 leave both fault-address registers unchanged.
- R8: A capture while status bits 0 and 3 are both clear loads the fault status register. The layout is bit 0 = correctable, bit 3 = uncorrectable, bits 7:4 = double-word index, bits 15:8 = syndrome, others 0. The same capture loads fault address 0 from `flt_info` and fault address 1 from `flt_pa`.
- R9: An uncorrectable capture always sets `irq` after the edge. A correctable capture sets it only when enable bits 0 and 1 are both 1.
- R10: A capture while status bit 0 or bit 3 is already set only sets status bit 16. It leaves the other status bits and both fault addresses unchanged.
- R11: When a capture and a fault status write fall in the same cycle, the capture wins, both for the register and for `irq`.
- R12: The video, diagnostic, event count 0 and event count 1 registers store full 32-bit words, each independently of the others.
- R13: For variant 0, a byte write at `diag_addr` stores into byte `diag_addr[1:0]`, and `diag_rdata` returns that byte. For variants 1 and 2, `diag_rdata` is always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| soft_rst | input | 1 | Synchronous reset that keeps selected enable bits |
| bus_addr | input | ADDR_W (6) | Byte address of the word access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| diag_addr | input | DIAG_AW (4) | Byte address of the diagnostic window |
| diag_wr | input | 1 | Diagnostic byte write strobe |
| diag_wdata | input | 8 | Diagnostic byte write data |
| diag_rdata | output | 8 | Diagnostic byte read data |
| flt_valid | input | 1 | One-cycle fault capture strobe |
| flt_uncorr | input | 1 | 1 = uncorrectable error, 0 = correctable |
| flt_dword | input | 4 | Double-word index within the burst |
| flt_synd | input | 8 | Error syndrome |
| flt_info | input | 32 | Word loaded into fault address 0 |
| flt_pa | input | 32 | Word loaded into fault address 1 |
| irq | output | 1 | Interrupt, high in state `IRQ_ALERT` |

## Verification
A wrong interrupt state shows on `irq` one cycle after the capture or status write that should have moved it. A wrong mask or decode shows on `bus_rdata` as soon as the index is read after the write, because reads are combinational. A fault-capture error that loses the first address shows only on the read that follows the second capture. So the bench reads both address words straight after each capture pair. It builds all three variants side by side on one shared bus, so the same stimulus compares their masks and their soft-reset retention.

// File: rtl/mc_regs_pkg.sv
package mc_regs_pkg;
    localparam int WORD_W = 32;
    localparam int NREG   = 9;

    localparam int IX_ENABLE = 0;
    localparam int IX_DELAY  = 1;
    localparam int IX_FSTAT  = 2;
    localparam int IX_VIDEO  = 3;
    localparam int IX_FADDR0 = 4;
    localparam int IX_FADDR1 = 5;
    localparam int IX_DIAG   = 6;
    localparam int IX_EVT0   = 7;
    localparam int IX_EVT1   = 8;

    localparam logic [WORD_W-1:0] DELAY_RST   = 32'h0000_0020;
    localparam logic [WORD_W-1:0] DELAY_WMASK = 32'h7FFF_FFFF;
    localparam logic [WORD_W-1:0] FADDR0_RST  = 32'h07C0_0000;

    localparam int FS_CE = 0;
    localparam int FS_UE = 3;
    localparam int FS_ME = 16;

    typedef enum logic [0:0] {
        IRQ_QUIET = 1'b0,
        IRQ_ALERT = 1'b1
    } irq_state_e;

    function automatic logic [WORD_W-1:0] variant_code(input int v);
        return WORD_W'(v) << 28;
    endfunction

    function automatic logic [WORD_W-1:0] enable_wmask(input int v);
        return (v == 0) ? 32'h0000_0103 : 32'h0000_0BFF;
    endfunction

    function automatic logic [WORD_W-1:0] enable_keep(input int v);
        return (v == 0) ? 32'h0000_0100 : 32'hFF00_0BFC;
    endfunction
endpackage

// File: rtl/mc_bus_decode.sv
module mc_bus_decode #(
    parameter int ADDR_W = 6,
    parameter int NREG   = 9,
    localparam int IDX_W = ADDR_W - 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output logic [IDX_W-1:0]  idx,
    output logic [NREG-1:0]   wr_sel
);
    logic unused_byte_lane;
    assign unused_byte_lane = ^addr[1:0];
    assign idx = addr[ADDR_W-1:2];

    for (genvar i = 0; i < NREG; i++) begin : g_sel
        assign wr_sel[i] = wr && (idx == IDX_W'(i));
    end
endmodule

// File: rtl/mc_fault_unit.sv
module mc_fault_unit
    import mc_regs_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              soft_rst,
    input  logic              fs_wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              chk_en,
    input  logic              ce_irq_en,
    input  logic              flt_valid,
    input  logic              flt_uncorr,
    input  logic [3:0]        flt_dword,
    input  logic [7:0]        flt_synd,
    input  logic [WORD_W-1:0] flt_info,
    input  logic [WORD_W-1:0] flt_pa,
    output logic [WORD_W-1:0] status,
    output logic [WORD_W-1:0] faddr0,
    output logic [WORD_W-1:0] faddr1,
    output logic              irq
);
    irq_state_e state_q, state_d;
    logic       raise;
    logic       busy;
    logic [WORD_W-1:0] fresh;

    assign raise = flt_valid && (flt_uncorr || (chk_en && ce_irq_en));
    assign busy  = status[FS_CE] || status[FS_UE];

    always_comb begin
        fresh            = '0;
        fresh[FS_CE]     = !flt_uncorr;
        fresh[FS_UE]     = flt_uncorr;
        fresh[7:4]       = flt_dword;
        fresh[15:8]      = flt_synd;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            status <= '0;
            faddr0 <= FADDR0_RST;
            faddr1 <= '0;
        end else if (soft_rst) begin
            status <= '0;
            faddr0 <= FADDR0_RST;
            faddr1 <= '0;
        end else if (flt_valid) begin
            if (busy) begin
                status[FS_ME] <= 1'b1;
            end else begin
                status <= fresh;
                faddr0 <= flt_info;
                faddr1 <= flt_pa;
            end
        end else if (fs_wr) begin
            status <= wdata;
        end
    end

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET: if (raise)           state_d = IRQ_ALERT;
            IRQ_ALERT: if (fs_wr && !raise) state_d = IRQ_QUIET;
        endcase
        if (soft_rst) state_d = IRQ_QUIET;
    end

    // outputs
    always_comb begin
        irq = (state_q == IRQ_ALERT);
    end

    a_r6_status_write_acks: assert property (@(posedge clk) disable iff (!por_n)
        (fs_wr && !flt_valid && !soft_rst) |=> !irq);
    a_r9_uncorr_raises: assert property (@(posedge clk) disable iff (!por_n)
        (flt_valid && flt_uncorr && !soft_rst) |=> irq);
    a_r10_second_fault_keeps_addr: assert property (@(posedge clk) disable iff (!por_n)
        (flt_valid && busy && !soft_rst) |=> (status[FS_ME] && $stable(faddr0) && $stable(faddr1)));
    a_r5_flush_quiets: assert property (@(posedge clk) disable iff (!por_n)
        soft_rst |=> (!irq && status == '0));
endmodule

// File: rtl/mc_diag_window.sv
module mc_diag_window #(
    parameter bit PRESENT = 1'b1,
    parameter int AW      = 4,
    parameter int NBYTES  = 4,
    localparam int SEL_W  = $clog2(NBYTES)
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic [AW-1:0] addr,
    input  logic          wr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    if (PRESENT) begin : g_window
        logic [7:0]       bytes_q [NBYTES];
        logic [SEL_W-1:0] sel;
        logic             unused_high;

        assign sel         = addr[SEL_W-1:0];
        assign unused_high = ^addr[AW-1:SEL_W];

        always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
                for (int i = 0; i < NBYTES; i++) bytes_q[i] <= '0;
            end else if (wr) begin
                bytes_q[sel] <= wdata;
            end
        end

        assign rdata = bytes_q[sel];

        a_r13_byte_lands: assert property (@(posedge clk) disable iff (!por_n)
            wr |=> (bytes_q[$past(sel)] == $past(wdata)));
    end else begin : g_absent
        logic unused_inputs;
        assign unused_inputs = ^{clk, por_n, addr, wr, wdata};
        assign rdata = '0;
    end
endmodule

// File: rtl/memctl_regfile.sv
module memctl_regfile
    import mc_regs_pkg::*;
#(
    parameter int VARIANT = 0,
    parameter int ADDR_W  = 6,
    parameter int DIAG_AW = 4
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              soft_rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [DIAG_AW-1:0] diag_addr,
    input  logic              diag_wr,
    input  logic [7:0]        diag_wdata,
    output logic [7:0]        diag_rdata,
    input  logic              flt_valid,
    input  logic              flt_uncorr,
    input  logic [3:0]        flt_dword,
    input  logic [7:0]        flt_synd,
    input  logic [31:0]       flt_info,
    input  logic [31:0]       flt_pa,
    output logic              irq
);
    localparam int IDX_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] VCODE = variant_code(VARIANT);
    localparam logic [WORD_W-1:0] EN_WM = enable_wmask(VARIANT);
    localparam logic [WORD_W-1:0] EN_KP = enable_keep(VARIANT);
    localparam bit   HAS_DIAG          = (VARIANT == 0);

    logic [IDX_W-1:0]  idx;
    logic [NREG-1:0]   wr_sel;
    logic [WORD_W-1:0] en_q, dly_q, vid_q, dr_q, ev0_q, ev1_q;
    logic [WORD_W-1:0] fstat, fa0, fa1;

    mc_bus_decode #(.ADDR_W(ADDR_W), .NREG(NREG)) u_decode (
        .addr   (bus_addr),
        .wr     (bus_wr),
        .idx    (idx),
        .wr_sel (wr_sel)
    );

    mc_fault_unit u_fault (
        .clk        (clk),
        .por_n      (por_n),
        .soft_rst   (soft_rst),
        .fs_wr      (wr_sel[IX_FSTAT]),
        .wdata      (bus_wdata),
        .chk_en     (en_q[0]),
        .ce_irq_en  (en_q[1]),
        .flt_valid  (flt_valid),
        .flt_uncorr (flt_uncorr),
        .flt_dword  (flt_dword),
        .flt_synd   (flt_synd),
        .flt_info   (flt_info),
        .flt_pa     (flt_pa),
        .status     (fstat),
        .faddr0     (fa0),
        .faddr1     (fa1),
        .irq        (irq)
    );

    mc_diag_window #(.PRESENT(HAS_DIAG), .AW(DIAG_AW), .NBYTES(4)) u_diag (
        .clk   (clk),
        .por_n (por_n),
        .addr  (diag_addr),
        .wr    (diag_wr),
        .wdata (diag_wdata),
        .rdata (diag_rdata)
    );

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            en_q  <= VCODE;
            dly_q <= DELAY_RST;
            vid_q <= '0;
            dr_q  <= '0;
            ev0_q <= '0;
            ev1_q <= '0;
        end else if (soft_rst) begin
            en_q  <= en_q & EN_KP;
            dly_q <= DELAY_RST;
            vid_q <= '0;
            dr_q  <= '0;
            ev0_q <= '0;
            ev1_q <= '0;
        end else begin
            if (wr_sel[IX_ENABLE]) en_q  <= VCODE | (bus_wdata & EN_WM);
            if (wr_sel[IX_DELAY])  dly_q <= bus_wdata & DELAY_WMASK;
            if (wr_sel[IX_VIDEO])  vid_q <= bus_wdata;
            if (wr_sel[IX_DIAG])   dr_q  <= bus_wdata;
            if (wr_sel[IX_EVT0])   ev0_q <= bus_wdata;
            if (wr_sel[IX_EVT1])   ev1_q <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (int'(idx))
            IX_ENABLE: bus_rdata = en_q;
            IX_DELAY:  bus_rdata = dly_q;
            IX_FSTAT:  bus_rdata = fstat;
            IX_VIDEO:  bus_rdata = vid_q;
            IX_FADDR0: bus_rdata = fa0;
            IX_FADDR1: bus_rdata = fa1;
            IX_DIAG:   bus_rdata = dr_q;
            IX_EVT0:   bus_rdata = ev0_q;
            IX_EVT1:   bus_rdata = ev1_q;
            default:   bus_rdata = '0;
        endcase
    end

    a_r2_variant_field: assert property (@(posedge clk) disable iff (!por_n)
        (wr_sel[IX_ENABLE] && !soft_rst) |=> (en_q[31:24] == VCODE[31:24]));
    a_r3_delay_top_clear: assert property (@(posedge clk) disable iff (!por_n)
        (wr_sel[IX_DELAY] && !soft_rst) |=> !dly_q[31]);
    a_r7_faddr_read_only: assert property (@(posedge clk) disable iff (!por_n)
        ((wr_sel[IX_FADDR0] || wr_sel[IX_FADDR1]) && !flt_valid && !soft_rst)
        |=> ($stable(fa0) && $stable(fa1)));
    a_r12_evt_independent: assert property (@(posedge clk) disable iff (!por_n)
        (wr_sel[IX_EVT1] && !soft_rst) |=> $stable(ev0_q));
endmodule

// File: tb/memctl_regfile_bench.sv
module memctl_regfile_bench;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  diag_addr = '0;
    logic        diag_wr = 1'b0;
    logic [7:0]  diag_wdata = '0;
    logic        flt_valid = 1'b0;
    logic        flt_uncorr = 1'b0;
    logic [3:0]  flt_dword = '0;
    logic [7:0]  flt_synd = '0;
    logic [31:0] flt_info = '0;
    logic [31:0] flt_pa = '0;

    logic [31:0] rdata [3];
    logic [7:0]  drd   [3];
    logic        irq   [3];

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_en [3];
    logic [7:0]  dmodel [4];

    always #4 clk = ~clk;

    memctl_regfile #(.VARIANT(0)) u_memctl_regfile (
        .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(rdata[0]),
        .diag_addr(diag_addr), .diag_wr(diag_wr), .diag_wdata(diag_wdata),
        .diag_rdata(drd[0]), .flt_valid(flt_valid), .flt_uncorr(flt_uncorr),
        .flt_dword(flt_dword), .flt_synd(flt_synd), .flt_info(flt_info),
        .flt_pa(flt_pa), .irq(irq[0]));
    memctl_regfile #(.VARIANT(1)) u_memctl_regfile_v1 (
        .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(rdata[1]),
        .diag_addr(diag_addr), .diag_wr(diag_wr), .diag_wdata(diag_wdata),
        .diag_rdata(drd[1]), .flt_valid(flt_valid), .flt_uncorr(flt_uncorr),
        .flt_dword(flt_dword), .flt_synd(flt_synd), .flt_info(flt_info),
        .flt_pa(flt_pa), .irq(irq[1]));
    memctl_regfile #(.VARIANT(2)) u_memctl_regfile_v2 (
        .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(rdata[2]),
        .diag_addr(diag_addr), .diag_wr(diag_wr), .diag_wdata(diag_wdata),
        .diag_rdata(drd[2]), .flt_valid(flt_valid), .flt_uncorr(flt_uncorr),
        .flt_dword(flt_dword), .flt_synd(flt_synd), .flt_info(flt_info),
        .flt_pa(flt_pa), .irq(irq[2]));

    function automatic logic [31:0] en_written(input int v, input logic [31:0] d);
        if (v == 0) return d & 32'h0000_0103;
        return (32'(v) << 28) | (d & 32'h0000_0BFF);
    endfunction

    function automatic logic [31:0] en_kept(input int v, input logic [31:0] e);
        if (v == 0) return e & 32'h0000_0100;
        return e & 32'hFF00_0BFC;
    endfunction

    task automatic chk(input string req, input int v, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s variant %0d actual %h expected %h", req, v, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        @(negedge clk);
        bus_addr = 6'(idx * 4);
        bus_wr = 1'b1;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_all(input string req, input int idx, input logic [31:0] e0,
                          input logic [31:0] e1, input logic [31:0] e2);
        bus_addr = 6'(idx * 4);
        #1;
        chk(req, 0, rdata[0], e0);
        chk(req, 1, rdata[1], e1);
        chk(req, 2, rdata[2], e2);
    endtask

    task automatic rd_same(input string req, input int idx, input logic [31:0] e);
        rd_all(req, idx, e, e, e);
    endtask

    task automatic irq_same(input string req, input logic e);
        chk(req, 0, 32'(irq[0]), 32'(e));
        chk(req, 1, 32'(irq[1]), 32'(e));
        chk(req, 2, 32'(irq[2]), 32'(e));
    endtask

    task automatic capture(input logic unc, input logic [3:0] dw, input logic [7:0] sy,
                           input logic [31:0] inf, input logic [31:0] pa,
                           input bit with_fs_write, input logic [31:0] fsval);
        @(negedge clk);
        flt_valid = 1'b1;
        flt_uncorr = unc;
        flt_dword = dw;
        flt_synd = sy;
        flt_info = inf;
        flt_pa = pa;
        if (with_fs_write) begin
            bus_addr = 6'(2 * 4);
            bus_wr = 1'b1;
            bus_wdata = fsval;
        end
        @(negedge clk);
        flt_valid = 1'b0;
        bus_wr = 1'b0;
    endtask

    task automatic pulse_soft();
        @(negedge clk);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);

        // R4 power-on values; R1 unmapped indexes read zero
        rd_all("R4 enable", 0, 32'h0, 32'h1000_0000, 32'h2000_0000);
        rd_same("R4 delay", 1, 32'h20);
        rd_same("R4 fstat", 2, 32'h0);
        rd_same("R4 video", 3, 32'h0);
        rd_same("R4 faddr0", 4, 32'h07C0_0000);
        for (int i = 5; i < 9; i++) rd_same("R4 zero reg", i, 32'h0);
        for (int i = 9; i < 16; i++) rd_same("R1 unmapped", i, 32'h0);
        irq_same("R4 irq", 1'b0);

        // R2 enable mask sweep: walking ones plus patterns
        for (int k = 0; k < 36; k++) begin
            logic [31:0] d;
            d = (k < 32) ? (32'h1 << k) :
                (k == 32) ? 32'hFFFF_FFFF : (k == 33) ? 32'hA5A5_A5A5 :
                (k == 34) ? 32'h5A5A_5A5A : 32'h0;
            wr(0, d);
            rd_all("R2 enable mask", 0, en_written(0, d), en_written(1, d), en_written(2, d));
        end

        // R3 delay mask
        wr(1, 32'hFFFF_FFFF);
        rd_same("R3 delay all ones", 1, 32'h7FFF_FFFF);
        wr(1, 32'h9234_5678);
        rd_same("R3 delay pattern", 1, 32'h1234_5678);

        // R12 full-word registers, stored independently
        wr(3, 32'h1111_0003);
        wr(6, 32'h6666_0006);
        wr(7, 32'h7777_0007);
        wr(8, 32'h8888_0008);
        rd_same("R12 video", 3, 32'h1111_0003);
        rd_same("R12 diag reg", 6, 32'h6666_0006);
        rd_same("R12 evt0", 7, 32'h7777_0007);
        rd_same("R12 evt1", 8, 32'h8888_0008);
        wr(8, 32'h0BAD_0808);
        rd_same("R12 evt0 after evt1 write", 7, 32'h7777_0007);
        rd_same("R12 evt1 rewrite", 8, 32'h0BAD_0808);

        // R7 fault address read-only
        wr(4, 32'hFFFF_FFFF);
        wr(5, 32'hFFFF_FFFF);
        rd_same("R7 faddr0", 4, 32'h07C0_0000);
        rd_same("R7 faddr1", 5, 32'h0);

        // R1 unmapped writes change nothing
        for (int i = 9; i < 16; i++) wr(i, 32'hFFFF_FFFF);
        for (int i = 9; i < 16; i++) rd_same("R1 unmapped after write", i, 32'h0);
        rd_same("R1 delay untouched", 1, 32'h1234_5678);
        rd_same("R1 video untouched", 3, 32'h1111_0003);

        // R8/R9 correctable capture, interrupts disabled
        wr(0, 32'h0);
        capture(1'b0, 4'h5, 8'hA7, 32'h1111_2222, 32'h3333_4444, 1'b0, 32'h0);
        rd_same("R8 status correctable", 2, 32'h0000_A751);
        rd_same("R8 faddr0 loaded", 4, 32'h1111_2222);
        rd_same("R8 faddr1 loaded", 5, 32'h3333_4444);
        irq_same("R9 corr with enables off", 1'b0);

        // R10 second capture while correctable bit set
        capture(1'b1, 4'h9, 8'h11, 32'hAAAA_AAAA, 32'hBBBB_BBBB, 1'b0, 32'h0);
        rd_same("R10 multiple bit", 2, 32'h0001_A751);
        rd_same("R10 faddr0 kept", 4, 32'h1111_2222);
        rd_same("R10 faddr1 kept", 5, 32'h3333_4444);
        irq_same("R9 uncorr raises even as second fault", 1'b1);
        wr(2, 32'h0);
        irq_same("R6 ack after second fault", 1'b0);

        // R9 correctable with both enables, R6 acknowledge
        wr(0, 32'h3);
        capture(1'b0, 4'h2, 8'h3C, 32'h0000_0001, 32'h0000_0002, 1'b0, 32'h0);
        irq_same("R9 corr with bits 0 and 1", 1'b1);
        rd_same("R8 status second pattern", 2, 32'h0000_3C21);
        wr(2, 32'h1234);
        irq_same("R6 status write clears irq", 1'b0);
        rd_same("R6 status stores word", 2, 32'h1234);

        // R9 checking only, no interrupt enable
        wr(0, 32'h1);
        wr(2, 32'h0);
        capture(1'b0, 4'h1, 8'h01, 32'h5, 32'h6, 1'b0, 32'h0);
        irq_same("R9 corr with only bit 0", 1'b0);
        wr(0, 32'h2);
        wr(2, 32'h0);
        capture(1'b0, 4'h1, 8'h01, 32'h5, 32'h6, 1'b0, 32'h0);
        irq_same("R9 corr with only bit 1", 1'b0);

        // R9 uncorrectable with enables off, R10 address kept
        wr(0, 32'h0);
        wr(2, 32'h0);
        capture(1'b1, 4'hF, 8'h81, 32'hCAFE_F00D, 32'h0BAD_BEEF, 1'b0, 32'h0);
        irq_same("R9 uncorr always", 1'b1);
        rd_same("R8 status uncorr", 2, 32'h0000_81F8);
        capture(1'b1, 4'h3, 8'h22, 32'h1, 32'h2, 1'b0, 32'h0);
        rd_same("R10 multiple after uncorr", 2, 32'h0001_81F8);
        rd_same("R10 faddr0 first kept", 4, 32'hCAFE_F00D);
        rd_same("R10 faddr1 first kept", 5, 32'h0BAD_BEEF);

        // R11 capture wins over same-cycle status write
        wr(2, 32'h0);
        irq_same("R6 ack before collision", 1'b0);
        capture(1'b1, 4'h1, 8'h55, 32'h1357_9BDF, 32'h2468_ACE0, 1'b1, 32'hDEAD_0000);
        rd_same("R11 capture wins status", 2, 32'h0000_5518);
        irq_same("R11 capture wins irq", 1'b1);
        rd_same("R11 faddr0 from capture", 4, 32'h1357_9BDF);

        // R5 soft reset retention, irq flushed
        wr(0, 32'hFFFF_FFFF);
        for (int v = 0; v < 3; v++) exp_en[v] = en_kept(v, en_written(v, 32'hFFFF_FFFF));
        wr(1, 32'h0000_0F0F);
        wr(7, 32'h0000_0077);
        pulse_soft();
        rd_all("R5 enable kept bits", 0, exp_en[0], exp_en[1], exp_en[2]);
        rd_same("R5 delay reset", 1, 32'h20);
        rd_same("R5 fstat reset", 2, 32'h0);
        rd_same("R5 video reset", 3, 32'h0);
        rd_same("R5 faddr0 reset", 4, 32'h07C0_0000);
        rd_same("R5 faddr1 reset", 5, 32'h0);
        rd_same("R5 diag reg reset", 6, 32'h0);
        rd_same("R5 evt0 reset", 7, 32'h0);
        rd_same("R5 evt1 reset", 8, 32'h0);
        irq_same("R5 irq flushed", 1'b0);
        wr(0, 32'h0000_0004);
        pulse_soft();
        rd_all("R5 enable low bit pattern", 0, 32'h0,
               en_kept(1, en_written(1, 32'h4)), en_kept(2, en_written(2, 32'h4)));

        // R13 diagnostic byte window with address masking
        for (int i = 0; i < 4; i++) dmodel[i] = 8'h00;
        for (int a = 0; a < 16; a++) begin
            @(negedge clk);
            diag_addr = 4'(a);
            diag_wr = 1'b1;
            diag_wdata = 8'((a * 37 + 5) & 8'hFF);
            dmodel[a % 4] = 8'((a * 37 + 5) & 8'hFF);
            @(negedge clk);
            diag_wr = 1'b0;
            for (int r = 0; r < 4; r++) begin
                diag_addr = 4'(r + 4 * ((a + r) % 4));
                #1;
                chk("R13 diag byte variant 0", 0, 32'(drd[0]), 32'(dmodel[r]));
                chk("R13 diag absent", 1, 32'(drd[1]), 32'h0);
                chk("R13 diag absent", 2, 32'(drd[2]), 32'h0);
            end
        end

        finish_run();
    end
endmodule